// File: doc/BRIEF.md
# Per-Address Deferred Register Commit

This block is a 64-entry bank of 16-bit configuration registers fronted by a shadow stage. A host write, delivered as a one-cycle strobe with an address and a 28-bit control word, always lands in the shadow copy. From there each address reaches the active copy on one of two paths. On the immediate path the value is copied at the same clock edge that accepts the write. On the deferred path the value stays in the shadow copy until the next rising edge of a frame-sync input. Downstream logic sees only the active copy, so a deferred group of settings changes together at a frame boundary.

Writable bitmask registers in the same address map pick the path for each address. Every group of sixteen data registers has an immediate-commit mask. The first three groups also have a frame-sync mask. A mask write takes effect at once, and both the masks and the active data can be read back.

Top module: `regbank_commit`

## Requirements
- R1: Addresses 0x00 to 0x3F hold the data registers, grouped so that group g covers 0x10*g to 0x10*g+15. Addresses 0x60 to 0x66 hold the masks in the order: group0 immediate, group0 frame-sync, group1 immediate, group1 frame-sync, group2 immediate, group2 frame-sync, group3 immediate. Bit n of a group's masks governs address 0x10*g+n.
- R2: After reset the masks at 0x60 to 0x66 read 0x1803, 0xE7FC, 0xF8FD, 0x0702, 0xFFF9, 0x0006 and 0xFFFF, in that order.
- R3: Only bits 15:0 of a written word are stored. Bits 27:16 have no effect on any register.
- R4: When the immediate bit of an address is set, a write to it shows on `activeFlat` bits [16a+15:16a] and on read-back in the cycle after the clock edge that sampled the write.
- R5: When the immediate bit is clear, the written value is held back and the active value does not change until a frame-sync commit. This holds whether or not the frame-sync bit is set, and it applies to every address of group 3 whose immediate bit is clear.
- R6: When both mask bits of an address are set, the immediate path is used.
- R7: For a rising edge of `frameSync` that falls between two clock edges, every pending address is committed together at the third rising clock edge after it. After that edge nothing remains pending.
- R8: If a write is sampled at that same commit edge, the address takes its earlier pending value at that edge (if it had one). The new value waits for the following frame-sync edge.
- R9: A mask write governs data writes from the next cycle on. It neither commits nor discards values that are already pending.
- R10: `rdData` follows `rdAddr` combinationally. It returns the active value for 0x00 to 0x3F, the mask for 0x60 to 0x66, and zero for every other address.
- R11: Reset clears every active and shadow data register to zero and leaves nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | One-cycle strobe marking a completed host write |
| wrAddr | input | 8 | Write address |
| wrData | input | 28 | Write word; bits 15:0 are stored |
| frameSync | input | 1 | Asynchronous frame-sync input; rising edge commits |
| rdAddr | input | 8 | Read-back address |
| rdData | output | 16 | Read-back value |
| activeFlat | output | 1024 | Active copy of all 64 data registers, address a at bits [16a+15:16a] |

## Verification
An immediate write is due one clock edge after the write is sampled. A mask write governs data writes from the next sample onward. A frame-sync rise is due to change the active copy at the third clock edge after it, and read-back has no latency of its own. The bench drives inputs on falling edges and updates its reference model at the same rising edge as the design. It compares two nanoseconds after that edge, every cycle. The directed checks around a frame-sync rise read the register after the first, second and third edges, so an off-by-one in the synchronizer shows up. The same-edge write is placed exactly on the commit edge by counting falling edges from the rise.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int DATA_W     = 16;
  localparam int CTRL_W     = 28;
  localparam int ADDR_W     = 8;
  localparam int GRP_SIZE   = 16;
  localparam int NUM_GRP    = 4;
  localparam int NUM_VD_GRP = 3;
  localparam int NUM_REGS   = GRP_SIZE * NUM_GRP;
  localparam int NUM_MASK   = NUM_GRP + NUM_VD_GRP;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam logic [ADDR_W-1:0] MASK_BASE = 8'h60;

  // Strobes from the control side to the register datapath
  typedef struct packed {
    logic [NUM_REGS-1:0] shadowWr;
    logic [NUM_REGS-1:0] immWr;
    logic                vdCommit;
    logic [DATA_W-1:0]   wrValue;
  } commitStrobes_t;

  // Mask slot holding the immediate mask of group g
  function automatic int immSlot(int g);
    return (g < NUM_VD_GRP) ? 2 * g : 2 * NUM_VD_GRP + (g - NUM_VD_GRP);
  endfunction

  function automatic logic [DATA_W-1:0] maskResetValue(int k);
    case (k)
      0:       return 16'h1803;
      1:       return 16'hE7FC;
      2:       return 16'hF8FD;
      3:       return 16'h0702;
      4:       return 16'hFFF9;
      5:       return 16'h0006;
      6:       return 16'hFFFF;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/regbank_vdsync.sv
module regbank_vdsync (
  input  logic clk,
  input  logic rstN,
  input  logic frameSync,
  output logic vdEdge
);
  logic syncA, syncB, syncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= frameSync;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end

  assign vdEdge = syncB & ~syncPrev;
endmodule

// File: rtl/regbank_ctrl.sv
module regbank_ctrl
  import regbank_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CTRL_W-1:0]     wrData,
  input  logic                  vdEdge,
  input  logic [ADDR_W-1:0]     rdAddr,
  output commitStrobes_t        strb,
  output logic                  rdMaskHit,
  output logic [DATA_W-1:0]     rdMaskVal
);
  logic [DATA_W-1:0]   maskReg [NUM_MASK];
  logic [NUM_REGS-1:0] immEn;
  logic                dataHit;
  logic                unusedHiBits;

  // Mask registers: stored bits take effect on the next cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_MASK; k++) maskReg[k] <= maskResetValue(k);
    end else if (wrEn) begin
      for (int k = 0; k < NUM_MASK; k++) begin
        if (wrAddr == MASK_BASE + ADDR_W'(k)) maskReg[k] <= wrData[DATA_W-1:0];
      end
    end
  end

  // Per-address immediate enable, one mask per group
  for (genvar g = 0; g < NUM_GRP; g++) begin : gImm
    assign immEn[g*GRP_SIZE +: GRP_SIZE] = maskReg[immSlot(g)];
  end

  assign dataHit = wrAddr < ADDR_W'(NUM_REGS);

  always_comb begin
    strb          = '0;
    strb.vdCommit = vdEdge;
    strb.wrValue  = wrData[DATA_W-1:0];
    if (wrEn && dataHit) strb.shadowWr = NUM_REGS'(1) << wrAddr[IDX_W-1:0];
    strb.immWr = strb.shadowWr & immEn;
  end

  always_comb begin
    rdMaskHit = 1'b0;
    rdMaskVal = '0;
    for (int k = 0; k < NUM_MASK; k++) begin
      if (rdAddr == MASK_BASE + ADDR_W'(k)) begin
        rdMaskHit = 1'b1;
        rdMaskVal = maskReg[k];
      end
    end
  end

  assign unusedHiBits = ^wrData[CTRL_W-1:DATA_W];
endmodule

// File: rtl/regbank_data.sv
module regbank_data
  import regbank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  commitStrobes_t             strb,
  input  logic [ADDR_W-1:0]          rdAddr,
  input  logic                       rdMaskHit,
  input  logic [DATA_W-1:0]          rdMaskVal,
  output logic [NUM_REGS*DATA_W-1:0] activeFlat,
  output logic [NUM_REGS-1:0]        pendingVec,
  output logic [DATA_W-1:0]          rdData
);
  logic [DATA_W-1:0] shadowReg [NUM_REGS];
  logic [DATA_W-1:0] activeReg [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        shadowReg[i]  <= '0;
        activeReg[i]  <= '0;
        pendingVec[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (strb.shadowWr[i]) shadowReg[i] <= strb.wrValue;
        // Immediate write outranks a commit of an older value
        if (strb.immWr[i])
          activeReg[i] <= strb.wrValue;
        else if (strb.vdCommit && pendingVec[i])
          activeReg[i] <= shadowReg[i];
        // A write landing on the commit edge stays pending
        if (strb.shadowWr[i])
          pendingVec[i] <= ~strb.immWr[i];
        else if (strb.vdCommit)
          pendingVec[i] <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : gFlat
    assign activeFlat[i*DATA_W +: DATA_W] = activeReg[i];
  end

  always_comb begin
    if (rdAddr < ADDR_W'(NUM_REGS))
      rdData = activeReg[rdAddr[IDX_W-1:0]];
    else if (rdMaskHit)
      rdData = rdMaskVal;
    else
      rdData = '0;
  end
endmodule

// File: rtl/regbank_commit.sv
module regbank_commit
  import regbank_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [ADDR_W-1:0]          wrAddr,
  input  logic [CTRL_W-1:0]          wrData,
  input  logic                       frameSync,
  input  logic [ADDR_W-1:0]          rdAddr,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_REGS*DATA_W-1:0] activeFlat
);
  commitStrobes_t      strb;
  logic                vdEdge;
  logic                rdMaskHit;
  logic [DATA_W-1:0]   rdMaskVal;
  logic [NUM_REGS-1:0] pendingVec;

  regbank_vdsync u_sync (
    .clk(clk), .rstN(rstN), .frameSync(frameSync), .vdEdge(vdEdge)
  );

  regbank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .vdEdge(vdEdge), .rdAddr(rdAddr), .strb(strb),
    .rdMaskHit(rdMaskHit), .rdMaskVal(rdMaskVal)
  );

  regbank_data u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr),
    .rdMaskHit(rdMaskHit), .rdMaskVal(rdMaskVal),
    .activeFlat(activeFlat), .pendingVec(pendingVec), .rdData(rdData)
  );
endmodule

// File: rtl/regbank_commit_chk.sv
module regbank_commit_chk
  import regbank_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       wrEn,
  input logic [ADDR_W-1:0]          wrAddr,
  input logic [DATA_W-1:0]          wrLow,
  input logic [ADDR_W-1:0]          rdAddr,
  input logic [DATA_W-1:0]          rdData,
  input logic [NUM_REGS*DATA_W-1:0] activeFlat,
  input logic [NUM_REGS-1:0]        immWr,
  input logic                       vdCommit,
  input logic [NUM_REGS-1:0]        pendingVec
);
  logic              dataHit, unmapped;
  logic [IDX_W-1:0]  wrIdx, seenIdx;
  logic              seenImm, seenDef, seenLate;
  logic [DATA_W-1:0] seenVal, seenOld, slotNow;

  assign dataHit  = wrAddr < ADDR_W'(NUM_REGS);
  assign wrIdx    = wrAddr[IDX_W-1:0];
  assign unmapped = !(rdAddr < ADDR_W'(NUM_REGS)) &&
                    !((rdAddr >= MASK_BASE) && (rdAddr < MASK_BASE + ADDR_W'(NUM_MASK)));
  assign slotNow  = activeFlat[int'(seenIdx)*DATA_W +: DATA_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenImm  <= 1'b0;
      seenDef  <= 1'b0;
      seenLate <= 1'b0;
      seenIdx  <= '0;
      seenVal  <= '0;
      seenOld  <= '0;
    end else begin
      seenImm  <= wrEn && dataHit && immWr[wrIdx];
      seenDef  <= wrEn && dataHit && !immWr[wrIdx] && !vdCommit;
      seenLate <= wrEn && dataHit && !immWr[wrIdx] && vdCommit;
      seenIdx  <= wrIdx;
      seenVal  <= wrLow;
      seenOld  <= activeFlat[int'(wrIdx)*DATA_W +: DATA_W];
    end
  end

  AST_IMM_VISIBLE: assert property (@(posedge clk) disable iff (!rstN) seenImm |-> slotNow == seenVal); // R4
  AST_IMM_NOT_PENDING: assert property (@(posedge clk) disable iff (!rstN) seenImm |-> !pendingVec[seenIdx]); // R4
  AST_DEFER_HELD: assert property (@(posedge clk) disable iff (!rstN) seenDef |-> slotNow == seenOld); // R5
  AST_DEFER_PENDING: assert property (@(posedge clk) disable iff (!rstN) seenDef |-> pendingVec[seenIdx]); // R5
  AST_LATE_WAITS: assert property (@(posedge clk) disable iff (!rstN) seenLate |-> pendingVec[seenIdx]); // R8
  AST_COMMIT_DRAINS: assert property (@(posedge clk) disable iff (!rstN) (vdCommit && !wrEn) |=> pendingVec == '0); // R7
  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rstN) vdCommit |=> !vdCommit); // R7
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN) unmapped |-> rdData == '0); // R10
endmodule

bind regbank_commit regbank_commit_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
  .wrLow(wrData[15:0]), .rdAddr(rdAddr), .rdData(rdData),
  .activeFlat(activeFlat), .immWr(strb.immWr), .vdCommit(strb.vdCommit),
  .pendingVec(pendingVec)
);

// File: tb/sim_regbank_commit.sv
module sim_regbank_commit;
  import regbank_pkg::*;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0, wrEn = 1'b0, frameSync = 1'b0;
  logic [7:0]  wrAddr = '0, rdAddr = '0;
  logic [27:0] wrData = '0;
  logic [15:0] rdData;
  logic [NUM_REGS*DATA_W-1:0] activeFlat;
  int nVec = 0, nBad = 0;

  regbank_commit u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameSync(frameSync), .rdAddr(rdAddr), .rdData(rdData), .activeFlat(activeFlat)
  );

  // Behavioural reference model
  logic [15:0] mActive [64];
  logic [15:0] mShadow [64];
  logic [15:0] mMask [7];
  bit          mPend [64];
  bit          vdHist [$];

  function automatic logic [15:0] modelRead(logic [7:0] a);
    if (a < 8'h40) return mActive[a];
    if (a >= 8'h60 && a <= 8'h66) return mMask[a - 8'h60];
    return 16'h0;
  endfunction

  always @(posedge clk) begin
    bit commit;
    int a, g, n, slot;
    if (!rstN) begin
      for (int i = 0; i < 64; i++) begin
        mActive[i] = '0; mShadow[i] = '0; mPend[i] = 0;
      end
      mMask[0] = 16'h1803; mMask[1] = 16'hE7FC; mMask[2] = 16'hF8FD;
      mMask[3] = 16'h0702; mMask[4] = 16'hFFF9; mMask[5] = 16'h0006;
      mMask[6] = 16'hFFFF;
      vdHist = {1'b0, 1'b0, 1'b0};
    end else begin
      commit = vdHist[1] && !vdHist[2];
      if (commit) begin
        for (int i = 0; i < 64; i++) begin
          if (mPend[i]) begin mActive[i] = mShadow[i]; mPend[i] = 0; end
        end
      end
      if (wrEn) begin
        a = int'(wrAddr);
        if (a < 64) begin
          g = a / 16; n = a % 16;
          slot = (g < 3) ? 2 * g : 6;
          mShadow[a] = wrData[15:0];
          if (mMask[slot][n]) begin mActive[a] = wrData[15:0]; mPend[a] = 0; end
          else mPend[a] = 1;
        end else if (a >= 96 && a <= 102) begin
          mMask[a - 96] = wrData[15:0];
        end
      end
      vdHist.push_front(frameSync);
      void'(vdHist.pop_back());
    end
  end

  // Per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rstN) begin
      int bad;
      bad = -1;
      nVec++;
      for (int i = 0; i < 64; i++)
        if (bad < 0 && activeFlat[i*16 +: 16] !== mActive[i]) bad = i;
      if (bad >= 0) begin
        nBad++;
        $display("FAIL R7 model activeFlat addr %0d actual %h expected %h",
                 bad, activeFlat[bad*16 +: 16], mActive[bad]);
      end
      nVec++;
      if (rdData !== modelRead(rdAddr)) begin
        nBad++;
        $display("FAIL R10 model rdData addr %h actual %h expected %h",
                 rdAddr, rdData, modelRead(rdAddr));
      end
    end
  end

  task automatic checkEq(string tag, logic [15:0] act, logic [15:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic expectRead(string tag, logic [7:0] a, logic [15:0] exp);
    rdAddr = a;
    #1;
    checkEq(tag, rdData, exp);
  endtask

  function automatic logic [15:0] slotOf(int a);
    return activeFlat[a*16 +: 16];
  endfunction

  task automatic writeReg(logic [7:0] a, logic [27:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic vdPulse();
    @(negedge clk) frameSync = 1'b1;
    idle(4);
    frameSync = 1'b0;
    idle(4);
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nBad++;
    $display("FAIL R7 watchdog expired actual running expected done");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R11 reset state
    nVec++;
    if (activeFlat !== '0) begin
      nBad++;
      $display("FAIL R11 activeFlat actual nonzero expected 0");
    end
    expectRead("R11 addr 00", 8'h00, 16'h0);
    // R2 mask reset values
    expectRead("R2 mask 60", 8'h60, 16'h1803);
    expectRead("R2 mask 61", 8'h61, 16'hE7FC);
    expectRead("R2 mask 62", 8'h62, 16'hF8FD);
    expectRead("R2 mask 63", 8'h63, 16'h0702);
    expectRead("R2 mask 64", 8'h64, 16'hFFF9);
    expectRead("R2 mask 65", 8'h65, 16'h0006);
    expectRead("R2 mask 66", 8'h66, 16'hFFFF);
    // R10 unmapped
    expectRead("R10 addr 40", 8'h40, 16'h0);
    expectRead("R10 addr 5F", 8'h5F, 16'h0);
    expectRead("R10 addr 67", 8'h67, 16'h0);
    expectRead("R10 addr FF", 8'hFF, 16'h0);

    // R4 / R3 immediate write with upper bits set
    writeReg(8'h00, 28'hABC1234);
    expectRead("R4 immediate 00", 8'h00, 16'h1234);
    checkEq("R3 upper bits dropped", slotOf(0), 16'h1234);
    writeReg(8'h61, 28'h5A5ABCD);
    expectRead("R1 mask slot 61", 8'h61, 16'hABCD);

    // R5 deferred then R7 timing
    writeReg(8'h02, 28'h0005555);
    expectRead("R5 deferred 02 held", 8'h02, 16'h0);
    @(negedge clk) frameSync = 1'b1;
    @(negedge clk); expectRead("R7 after edge 1", 8'h02, 16'h0);
    @(negedge clk); expectRead("R7 after edge 2", 8'h02, 16'h0);
    @(negedge clk); expectRead("R7 after edge 3", 8'h02, 16'h5555);
    frameSync = 1'b0;
    idle(4);

    // R9 / R6 mask change and both bits set
    writeReg(8'h21, 28'h0007777);
    expectRead("R5 deferred 21 held", 8'h21, 16'h0);
    writeReg(8'h64, 28'h000FFFF);
    expectRead("R9 mask readback", 8'h64, 16'hFFFF);
    writeReg(8'h22, 28'h0008888);
    expectRead("R6 both bits immediate", 8'h22, 16'h8888);
    expectRead("R9 pending kept", 8'h21, 16'h0);
    vdPulse();
    expectRead("R7 commit 21", 8'h21, 16'h7777);

    // R7 several addresses commit in one cycle
    writeReg(8'h03, 28'h0001111);
    writeReg(8'h11, 28'h0002222);
    @(negedge clk) frameSync = 1'b1;
    idle(2);
    checkEq("R7 03 before commit", slotOf(3), 16'h0);
    checkEq("R7 11 before commit", slotOf(17), 16'h0);
    idle(1);
    checkEq("R7 03 same cycle", slotOf(3), 16'h1111);
    checkEq("R7 11 same cycle", slotOf(17), 16'h2222);
    frameSync = 1'b0;
    idle(4);

    // R5 neither bit set, and group 3 without frame-sync mask
    writeReg(8'h60, 28'h0000000);
    writeReg(8'h00, 28'h0004321);
    expectRead("R5 neither bit held", 8'h00, 16'h1234);
    writeReg(8'h66, 28'h0000000);
    writeReg(8'h35, 28'h0009999);
    expectRead("R5 group3 held", 8'h35, 16'h0);
    writeReg(8'h02, 28'h000AAAA);
    expectRead("R5 02 held", 8'h02, 16'h5555);

    // R8 write sampled on the commit edge
    @(negedge clk) frameSync = 1'b1;
    idle(1);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'h02; wrData = 28'h000BBBB;
    @(negedge clk);
    wrEn = 1'b0;
    expectRead("R8 old value committed", 8'h02, 16'hAAAA);
    expectRead("R5 neither committed", 8'h00, 16'h4321);
    expectRead("R5 group3 committed", 8'h35, 16'h9999);
    frameSync = 1'b0;
    idle(4);
    expectRead("R8 new value waits", 8'h02, 16'hAAAA);
    vdPulse();
    expectRead("R8 next edge commits", 8'h02, 16'hBBBB);
    expectRead("R10 mask 65", 8'h65, 16'h0006);
    expectRead("R10 addr 50", 8'h50, 16'h0);

    idle(2);
    finishRun();
  end
endmodule